// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a 32-bit register-mapped timer that counts downward on prescaled ticks. When the count reaches zero, it either reloads from a programmable load value or wraps to all-ones. A separate compare value raises a sticky flag when the count lands on it. The flag drives a single interrupt line through an enable bit. Software clears the flag by writing 1 to it.

Two tick-enable inputs stand in for the available clock sources, and a two-bit field chooses between them. A 12-bit prescaler then divides the chosen tick stream. The block supports three other ways to set the counter:
- A load-register write can overwrite the running count at once.
- Enabling the timer in enable-mode restarts the count from a known value.
- A software-reset bit returns the timer to a quiet state.

Registers are addressed by word index: control 0, status 1, load 2, compare 3 and counter 4. The counter is read-only. Reads are combinational; writes take effect on the clock edge of the write cycle.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0xFFFFFFFF, status reads 0 and the interrupt output is low.
- R2: A control write stores bits 25:0 of the write data; control bits 31:26 always read 0, and bit 16 (software reset) always reads 0.
- R3: Control bits 25:24 select the tick source: 00 gives no ticks (counter frozen), 01 and 10 take the main tick input, and 11 takes the slow tick input.
- R4: Control bits 15:4 hold a prescaler P; the counter moves once every P+1 source ticks, and the prescale count restarts whenever the counter is started or reset.
- R5: On a tick the counter decrements. From zero it moves to the load value when control bit 3 (reload mode) is 1, otherwise to 0xFFFFFFFF.
- R6: A control write that sets bit 0 (enable) while enable was 0, with bit 1 (enable-mode) also set, starts the counter from the load value (bit 3 = 1) or 0xFFFFFFFF (bit 3 = 0). While enable is 0 the counter holds its value.
- R7: Writing the load register while control bit 17 (overwrite) is 1 puts the written value into the counter on that edge. This takes priority over a tick in the same cycle.
- R8: When control bit 2 (compare enable) is 1, a tick whose new count equals the compare register sets status bit 0. The flag is set once for that tick; counter starts and overwrites never set it.
- R9: Writing status with bit 0 = 1 clears the flag, and writing 0 leaves it. If the flag is set and cleared in the same cycle, the set wins.
- R10: The interrupt output equals status bit 0 AND control bit 2.
- R11: A control write with bit 16 set stores the written value with bits 0, 1, 16 and 21:18 cleared, clears the flag and sets the counter to 0xFFFFFFFF.
- R12: Writes to word 4 do not change the counter. Control bits 21:18 are stored and read back but do not change counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mainTick | input | 1 | Tick enable of the main clock source |
| slowTick | input | 1 | Tick enable of the slow clock source |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Compare interrupt |

## Verification
Two pairs of functions can fall in the same cycle.

- **Flag set and flag clear.** The bench preloads the counter through an overwrite three ticks above the compare value. It then issues the status clear on exactly the edge where the count lands on the compare value. The flag must read 1 afterwards.
- **Load overwrite and tick.** A load-register overwrite is issued while ticks arrive on every cycle. The counter must show the written value rather than the written value minus one.

A behavioural model in the bench also tracks every cycle. It compares read data and the interrupt output, so any other overlaps are judged too.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control field positions (software-visible layout)
  localparam int KEEP_W   = 26;
  localparam int EN_B     = 0;
  localparam int ENMOD_B  = 1;
  localparam int CMPIE_B  = 2;
  localparam int RLD_B    = 3;
  localparam int PSC_LO   = 4;
  localparam int PSC_W    = 12;
  localparam int SWR_B    = 16;
  localparam int OVW_B    = 17;
  localparam int LP_LO    = 18;
  localparam int LP_W     = 4;
  localparam int SRC_LO   = 24;
  localparam int SRC_W    = 2;

  // bits dropped from a control write that carries the software reset
  localparam logic [KEEP_W-1:0] SWR_CLR =
    KEEP_W'((((1 << LP_W) - 1) << LP_LO) | (1 << SWR_B) | (1 << ENMOD_B) | (1 << EN_B));

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_LOAD = 3'd2,
    REG_CMP  = 3'd3,
    REG_CNT  = 3'd4
  } regIdx_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE  = 2'b00,
    SRC_MAIN  = 2'b01,
    SRC_MAINB = 2'b10,
    SRC_SLOW  = 2'b11
  } tickSrc_e;

  typedef struct packed {
    logic tick;       // prescaled tick, counter may move
    logic swReset;    // software reset this cycle
    logic overwrite;  // load write copies into counter
    logic startLoad;  // enable-mode start from load value
    logic startMax;   // enable-mode start from all-ones
    logic flagClr;    // write-1-to-clear on status
    logic cmpEn;      // compare enable
    logic reloadMode; // reload from load value at zero
  } strobes_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mainTick,
  input  logic              slowTick,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [KEEP_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] loadQ,
  output logic [DATA_W-1:0] cmpQ,
  output strobes_t          st
);
  logic [PSC_W-1:0]  preCnt;
  logic [PSC_W-1:0]  pscVal;
  logic [KEEP_W-1:0] wNew;
  logic              wrCtrl, wrStat, wrLoad, wrCmp;
  logic              rawTick, preHit, enNow, swr, enRise;
  tickSrc_e          srcSel;

  assign wrCtrl = busWe && (busAddr == REG_CTRL);
  assign wrStat = busWe && (busAddr == REG_STAT);
  assign wrLoad = busWe && (busAddr == REG_LOAD);
  assign wrCmp  = busWe && (busAddr == REG_CMP);

  assign wNew   = busWdata[KEEP_W-1:0];
  assign pscVal = ctrlQ[PSC_LO +: PSC_W];
  assign enNow  = ctrlQ[EN_B];
  assign srcSel = tickSrc_e'(ctrlQ[SRC_LO +: SRC_W]);

  always_comb begin
    unique case (srcSel)
      SRC_MAIN, SRC_MAINB: rawTick = mainTick;
      SRC_SLOW:            rawTick = slowTick;
      default:             rawTick = 1'b0;
    endcase
  end

  assign preHit = (preCnt == pscVal);
  assign swr    = wrCtrl && wNew[SWR_B];
  assign enRise = wrCtrl && !swr && !enNow && wNew[EN_B] && wNew[ENMOD_B];

  always_comb begin
    st            = '0;
    st.tick       = enNow && rawTick && preHit;
    st.swReset    = swr;
    st.overwrite  = wrLoad && ctrlQ[OVW_B];
    st.startLoad  = enRise && wNew[RLD_B];
    st.startMax   = enRise && !wNew[RLD_B];
    st.flagClr    = wrStat && busWdata[0];
    st.cmpEn      = ctrlQ[CMPIE_B];
    st.reloadMode = ctrlQ[RLD_B];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      loadQ  <= '0;
      cmpQ   <= '0;
      preCnt <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= swr ? (wNew & ~SWR_CLR) : wNew;
      if (wrLoad) loadQ <= busWdata;
      if (wrCmp)  cmpQ  <= busWdata;
      if (swr || enRise)         preCnt <= '0;
      else if (enNow && rawTick) preCnt <= preHit ? '0 : preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] loadQ,
  input  logic [DATA_W-1:0] cmpQ,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntQ,
  output logic              flagQ
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] nextCnt;
  logic              killTick, hit;

  assign nextCnt  = (cntQ == '0) ? (st.reloadMode ? loadQ : ALL_ONES) : cntQ - 1'b1;
  assign killTick = st.swReset || st.overwrite || st.startLoad || st.startMax;
  assign hit      = st.tick && !killTick && st.cmpEn && (nextCnt == cmpQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= ALL_ONES;
      flagQ <= 1'b0;
    end else begin
      if (st.swReset)        cntQ <= ALL_ONES;
      else if (st.overwrite) cntQ <= wrData;
      else if (st.startLoad) cntQ <= loadQ;
      else if (st.startMax)  cntQ <= ALL_ONES;
      else if (st.tick)      cntQ <= nextCnt;

      if (st.swReset)    flagQ <= 1'b0;
      else if (hit)      flagQ <= 1'b1;
      else if (st.flagClr) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mainTick,
  input  logic              slowTick,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] ctrlQ;
  logic [DATA_W-1:0] loadQ, cmpQ, cntQ;
  logic              flagQ, tickStrobe;
  strobes_t          st;

  tmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mainTick(mainTick), .slowTick(slowTick),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .ctrlQ(ctrlQ), .loadQ(loadQ), .cmpQ(cmpQ), .st(st)
  );

  tmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .loadQ(loadQ), .cmpQ(cmpQ),
    .wrData(busWdata), .cntQ(cntQ), .flagQ(flagQ)
  );

  assign tickStrobe = st.tick;
  assign irqOut     = flagQ && ctrlQ[CMPIE_B];

  always_comb begin
    case (busAddr)
      REG_CTRL: busRdata = {{PAD_W{1'b0}}, ctrlQ};
      REG_STAT: busRdata = {{(DATA_W-1){1'b0}}, flagQ};
      REG_LOAD: busRdata = loadQ;
      REG_CMP:  busRdata = cmpQ;
      REG_CNT:  busRdata = cntQ;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [KEEP_W-1:0] ctrlQ,
  input logic [DATA_W-1:0] loadQ,
  input logic [DATA_W-1:0] cntQ,
  input logic              flagQ,
  input logic              tickStrobe
);
  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[EN_B] && !busWe) |=> $stable(cntQ));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickStrobe && cntQ == '0 && !busWe && !ctrlQ[RLD_B]) |=> (cntQ == '1));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickStrobe && cntQ == '0 && !busWe && ctrlQ[RLD_B]) |=> (cntQ == $past(loadQ)));

  // R7
  overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_LOAD && ctrlQ[OVW_B]) |=> (cntQ == $past(busWdata)));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_CTRL && busWdata[SWR_B])
      |=> (cntQ == '1 && !flagQ && !ctrlQ[EN_B] && !ctrlQ[SWR_B]));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_STAT && busWdata[0] && !tickStrobe) |=> !flagQ);

  // R3
  no_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[SRC_LO +: SRC_W] == 2'b00) |-> !tickStrobe);
endmodule

bind periodic_tick_timer tmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .ctrlQ(ctrlQ), .loadQ(loadQ), .cntQ(cntQ), .flagQ(flagQ), .tickStrobe(tickStrobe)
);

// File: tb/test_periodic_tick_timer.sv
`timescale 1ns/1ps
module test_periodic_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mainTick = 1'b1;
  logic        slowTick = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd4;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  int          checks = 0;
  int          fails = 0;
  int          slowDiv = 0;
  bit          done = 1'b0;

  periodic_tick_timer i_periodic_tick_timer (
    .clk(clk), .rstN(rstN), .mainTick(mainTick), .slowTick(slowTick),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    slowDiv  <= (slowDiv + 1) % 4;
    slowTick <= (slowDiv == 3);
  end

  // behavioural reference model
  logic [25:0] mCtrl, nCtrl;
  logic [31:0] mLoad, mCmp, mCnt, nLoad, nCmp, nCnt, decVal;
  logic        mFlag, nFlag, raw, tk, killed;
  int          mPre, nPre;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mLoad = '0; mCmp = '0; mCnt = '1; mFlag = 1'b0; mPre = 0;
    end else begin
      case (mCtrl[25:24])
        2'b00:   raw = 1'b0;
        2'b11:   raw = slowTick;
        default: raw = mainTick;
      endcase
      tk = mCtrl[0] && raw && (mPre == int'(mCtrl[15:4]));
      decVal = (mCnt == 0) ? (mCtrl[3] ? mLoad : 32'hFFFF_FFFF) : mCnt - 1;
      nCtrl = mCtrl; nLoad = mLoad; nCmp = mCmp; nCnt = mCnt; nFlag = mFlag;
      nPre = mPre; killed = 1'b0;
      if (tk) nCnt = decVal;
      if (mCtrl[0] && raw) nPre = (mPre == int'(mCtrl[15:4])) ? 0 : mPre + 1;
      if (busWe) begin
        case (busAddr)
          3'd0: begin
            if (busWdata[16]) begin
              nCtrl = busWdata[25:0] & ~26'h03D_0003;
              nCnt = '1; nFlag = 1'b0; nPre = 0; killed = 1'b1;
            end else begin
              nCtrl = busWdata[25:0];
              if (!mCtrl[0] && busWdata[0] && busWdata[1]) begin
                nCnt = busWdata[3] ? mLoad : 32'hFFFF_FFFF;
                nPre = 0; killed = 1'b1;
              end
            end
          end
          3'd1: if (busWdata[0]) nFlag = 1'b0;
          3'd2: begin
            nLoad = busWdata;
            if (mCtrl[17]) begin nCnt = busWdata; killed = 1'b1; end
          end
          3'd3: nCmp = busWdata;
          default: ;
        endcase
      end
      if (tk && !killed && mCtrl[2] && decVal == mCmp) nFlag = 1'b1;
      mCtrl = nCtrl; mLoad = nLoad; mCmp = nCmp; mCnt = nCnt; mFlag = nFlag; mPre = nPre;
    end
  end

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0:    return {6'd0, mCtrl};
      3'd1:    return {31'd0, mFlag};
      3'd2:    return mLoad;
      3'd3:    return mCmp;
      3'd4:    return mCnt;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      #1;
      check("R5 read data vs model", busRdata, mRead(busAddr));
      check("R10 irq vs model", {31'd0, irqOut}, {31'd0, mFlag & mCtrl[2]});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busAddr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nowChk(input logic [2:0] a, input logic [31:0] exp, input string req);
    busAddr = a;
    #2;
    check(req, busRdata, exp);
    busAddr = 3'd4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    nowChk(3'd0, 32'h0, "R1 ctrl");
    nowChk(3'd4, 32'hFFFF_FFFF, "R1 counter");
    nowChk(3'd1, 32'h0, "R1 status");
    check("R1 irq", {31'd0, irqOut}, 32'h0);

    // R2 field retention, R12 low-power bits stored
    wr(3'd0, 32'hFFFE_FFF0);
    nowChk(3'd0, 32'h03FE_FFF0, "R2 ctrl keeps 25:0");
    nowChk(3'd4, 32'hFFFF_FFFF, "R12 low-power bits no effect");
    wr(3'd0, 32'h0);

    // R6 start from load, R5 reload
    wr(3'd2, 32'd5);
    wr(3'd0, 32'h0100_000B);
    nowChk(3'd4, 32'd5, "R6 start from load");
    idle(5);
    nowChk(3'd4, 32'd0, "R5 count to zero");
    idle(1);
    nowChk(3'd4, 32'd5, "R5 reload at zero");

    // R8 compare flag, R10 gating, R9 clear, R6 freeze
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h0100_000F);
    idle(8);
    nowChk(3'd1, 32'd1, "R8 compare flag");
    check("R10 irq high", {31'd0, irqOut}, 32'd1);
    wr(3'd0, 32'h0100_000C);
    busAddr = 3'd4; #2 v = busRdata; busAddr = 3'd4;
    idle(3);
    nowChk(3'd4, v, "R6 frozen when disabled");
    wr(3'd0, 32'h0100_0008);
    check("R10 irq gated off", {31'd0, irqOut}, 32'd0);
    wr(3'd1, 32'd0);
    nowChk(3'd1, 32'd1, "R9 write 0 keeps flag");
    wr(3'd1, 32'd1);
    nowChk(3'd1, 32'd0, "R9 write 1 clears flag");

    // R4 prescaler 2 -> divide by 3
    wr(3'd2, 32'd10);
    wr(3'd0, 32'h0100_002B);
    nowChk(3'd4, 32'd10, "R4 start");
    idle(2);
    nowChk(3'd4, 32'd10, "R4 held two cycles");
    idle(1);
    nowChk(3'd4, 32'd9, "R4 third cycle ticks");
    wr(3'd0, 32'h0);

    // R3 tick sources
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h0000_000B);
    idle(5);
    nowChk(3'd4, 32'd100, "R3 source 00 no tick");
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0300_000B);
    idle(8);
    busAddr = 3'd4; #2 v = busRdata;
    check("R3 slow source count", {31'd0, (v < 32'd100) && (v >= 32'd97)}, 32'd1);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0200_000B);
    idle(3);
    nowChk(3'd4, 32'd97, "R3 source 10 main tick");

    // R7 overwrite, R5 wrap
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0102_0001);
    wr(3'd2, 32'd2);
    nowChk(3'd4, 32'd2, "R7 immediate overwrite");
    idle(2);
    nowChk(3'd4, 32'd0, "R5 reach zero");
    idle(1);
    nowChk(3'd4, 32'hFFFF_FFFF, "R5 wrap to all-ones");

    // R9 set and clear in the same cycle; R7 overwrite beats tick
    wr(3'd0, 32'h0102_0005);
    wr(3'd3, 32'd50);
    wr(3'd2, 32'd53);
    nowChk(3'd4, 32'd53, "R7 overwrite wins over tick");
    idle(1);
    wr(3'd1, 32'd1);
    nowChk(3'd1, 32'd1, "R9 set wins over clear");

    // R12 counter read-only
    wr(3'd0, 32'h0);
    busAddr = 3'd4; #2 v = busRdata;
    wr(3'd4, 32'h1234_5678);
    nowChk(3'd4, v, "R12 counter write ignored");

    // R11 software reset
    wr(3'd0, 32'h013F_0007);
    nowChk(3'd0, 32'h0102_0004, "R11 ctrl after soft reset");
    nowChk(3'd4, 32'hFFFF_FFFF, "R11 counter all-ones");
    nowChk(3'd1, 32'd0, "R11 flag cleared");
    check("R11 irq low", {31'd0, irqOut}, 32'd0);

    idle(4);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule